// File: doc/BRIEF.md
# Microcoded Fetch and Dispatch Sequencer

This block is the control unit of a small CPU built around three buses: two source buses feeding an ALU and one result bus that loads a destination register. A micromemory holds one control word per micro-address. A micro-program counter steps through it, and each word drives the datapath controls directly: the source selected onto each input bus, the ALU function, the register loaded from the result bus, and a memory read strobe.

Every machine instruction starts with the same fetch routine at micro-address 0x20. That routine reads memory at the program counter, increments the program counter, and copies the memory buffer into the instruction register. It ends in a dispatch word, which selects the next micro-address from the opcode presented on the instruction-register input. There are no micro-calls and no saved return address. Each execution routine therefore finishes with a plain jump back to 0x20. Opcodes without a routine land on a word that only jumps back to fetch. While a word asserts the read strobe and memory has not signalled ready, the sequencer holds its address. The current micro-address is brought out so that the control flow can be observed.

Top module: `mseq_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the micro-address becomes 0x20 at that edge. This also holds when the sequencer is in the middle of a routine.
- R2: The word at 0x20 drives `b1_sel`=1 (program counter), `alu_fn`=1 (pass bus 1), `dst_ld`=1 (MAR) and `mem_read`=1.
- R3: While `mem_read` is 1 and `mem_ready` is 0, the micro-address does not change. On the first edge with `mem_ready`=1 it advances.
- R4: The word at 0x21 drives `b1_sel`=1, `b2_sel`=1 (constant one), `alu_fn`=3 (add) and `dst_ld`=2 (program counter), with `mem_read`=0.
- R5: The word at 0x22 drives `b2_sel`=2 (MBR), `alu_fn`=2 (pass bus 2) and `dst_ld`=3 (instruction register), with `b1_sel`=0.
- R6: The word at 0x23 is a dispatch with all controls idle. The next micro-address comes from `ir_opcode` as sampled in that cycle: 1→0x80, 2→0x88, 3→0x90.
- R7: The word at 0x80 drives `b1_sel`=2, `b2_sel`=3 (general registers), `alu_fn`=4 (AND) and `dst_ld`=4 (general register). The word at 0x81 jumps to 0x20, so an AND instruction visits 0x20, 0x21, 0x22, 0x23, 0x80, 0x81, 0x20.
- R8: Any opcode other than 1, 2 and 3 dispatches to 0x30. That word has all controls idle and jumps to 0x20.
- R9: `mem_ready` has no effect on a word whose `mem_read` is 0. Such a word advances even when `mem_ready` is 0.
- R10: The word at 0x88 drives the AND bus and destination selects with `alu_fn`=5 (OR). The word at 0x90 does the same with `alu_fn`=3 (add). Each routine's second word jumps to 0x20.
- R11: Each jump-back word (0x81, 0x89, 0x91, 0x30) drives all of `b1_sel`, `b2_sel`, `alu_fn`, `dst_ld` and `mem_read` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_opcode | input | OPW | Opcode held in the instruction register |
| mem_ready | input | 1 | Memory has completed the outstanding read |
| b1_sel | output | 2 | Source on bus 1: 0 none, 1 program counter, 2 general register |
| b2_sel | output | 2 | Source on bus 2: 0 none, 1 constant one, 2 MBR, 3 general register |
| alu_fn | output | 3 | 0 none, 1 pass bus 1, 2 pass bus 2, 3 add, 4 AND, 5 OR |
| dst_ld | output | 3 | Load from bus 3: 0 none, 1 MAR, 2 program counter, 3 IR, 4 general register |
| mem_read | output | 1 | Memory read strobe |
| uaddr | output | 8 | Current micro-address |

## Verification
The hardest conditions to reach from the ports are those where timing-sensitive inputs change at exactly the right moment. One is a read stall that lasts several cycles. Another is an opcode that changes just as the dispatch word is reached. A third is a reset that arrives while an execution routine is running. The stimulus holds `mem_ready` low across several edges while 0x20 is current, then releases it. It presents each opcode only in the cycle the sequencer sits on 0x23. It asserts reset while 0x80 is current. Separately, it drops `mem_ready` on a non-read word to show that the sequencer advances regardless.

// File: rtl/mseq_pkg.sv
// Package: shared encodings and micro-addresses for the fetch/dispatch sequencer.
// Assumes an 8-bit micro-address space; control codes are the port encodings.
package mseq_pkg;

    localparam int UADDR_W = 8;

    localparam logic [UADDR_W-1:0] FETCH_ADDR  = 8'h20;
    localparam logic [UADDR_W-1:0] BADOP_ADDR  = 8'h30;
    localparam logic [UADDR_W-1:0] AND_ADDR    = 8'h80;
    localparam logic [UADDR_W-1:0] OR_ADDR     = 8'h88;
    localparam logic [UADDR_W-1:0] ADD_ADDR    = 8'h90;

    typedef enum logic [1:0] {
        SQ_NEXT     = 2'd0,
        SQ_JUMP     = 2'd1,
        SQ_DISPATCH = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        S1_NONE = 2'd0,
        S1_PC   = 2'd1,
        S1_GPR  = 2'd2
    } bus1_e;

    typedef enum logic [1:0] {
        S2_NONE = 2'd0,
        S2_ONE  = 2'd1,
        S2_MBR  = 2'd2,
        S2_GPR  = 2'd3
    } bus2_e;

    typedef enum logic [2:0] {
        FN_NONE  = 3'd0,
        FN_PASS1 = 3'd1,
        FN_PASS2 = 3'd2,
        FN_ADD   = 3'd3,
        FN_AND   = 3'd4,
        FN_OR    = 3'd5
    } alu_e;

    typedef enum logic [2:0] {
        LD_NONE = 3'd0,
        LD_MAR  = 3'd1,
        LD_PC   = 3'd2,
        LD_IR   = 3'd3,
        LD_GPR  = 3'd4
    } dst_e;

    typedef struct packed {
        seq_e                seq;
        logic [UADDR_W-1:0]  target;
        bus1_e               b1;
        bus2_e               b2;
        alu_e                fn;
        dst_e                dst;
        logic                rd;
    } uword_t;

    // Builds a word that only sequences, with every control idle.
    function automatic uword_t idle_word(seq_e s, logic [UADDR_W-1:0] t);
        uword_t w;
        w.seq    = s;
        w.target = t;
        w.b1     = S1_NONE;
        w.b2     = S2_NONE;
        w.fn     = FN_NONE;
        w.dst    = LD_NONE;
        w.rd     = 1'b0;
        return w;
    endfunction

    // Builds a datapath word that falls through to the next address.
    function automatic uword_t op_word(bus1_e a, bus2_e b, alu_e f, dst_e d, logic r);
        uword_t w;
        w.seq    = SQ_NEXT;
        w.target = '0;
        w.b1     = a;
        w.b2     = b;
        w.fn     = f;
        w.dst    = d;
        w.rd     = r;
        return w;
    endfunction

endpackage

// File: rtl/mseq_ustore.sv
// Module: micromemory holding the fetch routine, execution routines and
// the undefined-opcode trap. Pure combinational read; every address not
// listed holds a jump to fetch so a stray address recovers.
module mseq_ustore
    import mseq_pkg::*;
(
    input  logic [UADDR_W-1:0] addr,
    output uword_t             word
);

    // Decode the micro-address into its stored control word.
    always_comb begin
        unique case (addr)
            8'h20:   word = op_word(S1_PC,   S2_NONE, FN_PASS1, LD_MAR, 1'b1);
            8'h21:   word = op_word(S1_PC,   S2_ONE,  FN_ADD,   LD_PC,  1'b0);
            8'h22:   word = op_word(S1_NONE, S2_MBR,  FN_PASS2, LD_IR,  1'b0);
            8'h23:   word = idle_word(SQ_DISPATCH, '0);
            8'h30:   word = idle_word(SQ_JUMP, FETCH_ADDR);
            8'h80:   word = op_word(S1_GPR,  S2_GPR,  FN_AND,   LD_GPR, 1'b0);
            8'h81:   word = idle_word(SQ_JUMP, FETCH_ADDR);
            8'h88:   word = op_word(S1_GPR,  S2_GPR,  FN_OR,    LD_GPR, 1'b0);
            8'h89:   word = idle_word(SQ_JUMP, FETCH_ADDR);
            8'h90:   word = op_word(S1_GPR,  S2_GPR,  FN_ADD,   LD_GPR, 1'b0);
            8'h91:   word = idle_word(SQ_JUMP, FETCH_ADDR);
            default: word = idle_word(SQ_JUMP, FETCH_ADDR);
        endcase
    end

endmodule

// File: rtl/mseq_dispmap.sv
// Module: opcode-indexed table of execution routine start addresses.
// Assumes opcodes 1, 2 and 3 are the only defined ones; all other entries
// point to the trap word that returns to fetch.
module mseq_dispmap
    import mseq_pkg::*;
#(
    parameter int OPW = 4
) (
    input  logic [OPW-1:0]     opcode,
    output logic [UADDR_W-1:0] start
);

    localparam int NOPS = 1 << OPW;

    logic [UADDR_W-1:0] table_q [NOPS];

    // One table entry per opcode, chosen at elaboration.
    for (genvar i = 0; i < NOPS; i++) begin : g_ent
        if (i == 1) begin : g_and
            assign table_q[i] = AND_ADDR;
        end else if (i == 2) begin : g_or
            assign table_q[i] = OR_ADDR;
        end else if (i == 3) begin : g_add
            assign table_q[i] = ADD_ADDR;
        end else begin : g_bad
            assign table_q[i] = BADOP_ADDR;
        end
    end

    assign start = table_q[opcode];

endmodule

// File: rtl/mseq_upc.sv
// Module: micro-program counter and next-address selection.
// Assumes the read strobe of the current word is the only stall source.
module mseq_upc
    import mseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  seq_e               seq,
    input  logic [UADDR_W-1:0] target,
    input  logic [UADDR_W-1:0] disp_addr,
    input  logic               rd,
    input  logic               mem_ready,
    output logic [UADDR_W-1:0] upc
);

    logic [UADDR_W-1:0] nxt;
    logic               stall;

    assign stall = rd && !mem_ready;

    // Choose the successor address from the sequencing code.
    always_comb begin
        unique case (seq)
            SQ_JUMP:     nxt = target;
            SQ_DISPATCH: nxt = disp_addr;
            default:     nxt = upc + 1'b1;
        endcase
    end

    // Hold on a stalled read, otherwise step to the chosen successor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc <= FETCH_ADDR;
        end else if (!stall) begin
            upc <= nxt;
        end
    end

endmodule

// File: rtl/mseq_top.sv
// Module: microcoded fetch/dispatch control unit for a three-bus datapath.
// Assumes ir_opcode is stable while the dispatch word is current and that
// mem_ready answers the read strobe of the word at 0x20.
module mseq_top
    import mseq_pkg::*;
#(
    parameter int OPW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPW-1:0]     ir_opcode,
    input  logic               mem_ready,
    output logic [1:0]         b1_sel,
    output logic [1:0]         b2_sel,
    output logic [2:0]         alu_fn,
    output logic [2:0]         dst_ld,
    output logic               mem_read,
    output logic [UADDR_W-1:0] uaddr
);

    uword_t             cur;
    logic [UADDR_W-1:0] upc;
    logic [UADDR_W-1:0] disp_addr;

    mseq_ustore u_store (
        .addr (upc),
        .word (cur)
    );

    mseq_dispmap #(.OPW(OPW)) u_map (
        .opcode (ir_opcode),
        .start  (disp_addr)
    );

    mseq_upc u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq       (cur.seq),
        .target    (cur.target),
        .disp_addr (disp_addr),
        .rd        (cur.rd),
        .mem_ready (mem_ready),
        .upc       (upc)
    );

    assign b1_sel   = cur.b1;
    assign b2_sel   = cur.b2;
    assign alu_fn   = cur.fn;
    assign dst_ld   = cur.dst;
    assign mem_read = cur.rd;
    assign uaddr    = upc;

endmodule

// File: rtl/mseq_chk.sv
// Module: property checker for mseq_top, attached by bind below.
module mseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_ready,
    input logic       mem_read,
    input logic [2:0] alu_fn,
    input logic [2:0] dst_ld,
    input logic [7:0] uaddr
);

    // R1: reset lands on the fetch address
    a_r1_reset_fetch: assert property (@(posedge clk)
        !rst_n |=> uaddr == 8'h20);

    // R2: fetch start issues a read into MAR
    a_r2_fetch_read: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == 8'h20 |-> (mem_read && dst_ld == 3'd1));

    // R3: stalled read holds the address
    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read && !mem_ready) |=> $stable(uaddr));

    // R6: dispatch goes only to a routine start or the trap
    a_r6_dispatch_dest: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == 8'h23 |=> (uaddr == 8'h80 || uaddr == 8'h88 ||
                            uaddr == 8'h90 || uaddr == 8'h30));

    // R7: AND routine returns to fetch
    a_r7_and_return: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == 8'h81 |=> uaddr == 8'h20);

    // R8: trap returns to fetch
    a_r8_trap_return: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == 8'h30 |=> uaddr == 8'h20);

    // R9: a word without a read always moves on
    a_r9_no_read_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_read |=> !$stable(uaddr));

    // R11: jump-back words keep the ALU idle
    a_r11_return_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == 8'h81 || uaddr == 8'h30) |-> (alu_fn == 3'd0 && dst_ld == 3'd0));

endmodule

bind mseq_top mseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ready (mem_ready),
    .mem_read  (mem_read),
    .alu_fn    (alu_fn),
    .dst_ld    (dst_ld),
    .uaddr     (uaddr)
);

// File: tb/sim_mseq_top.sv
module sim_mseq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ir_opcode = 4'd0;
    logic       mem_ready = 1'b1;
    logic [1:0] b1_sel, b2_sel;
    logic [2:0] alu_fn, dst_ld;
    logic       mem_read;
    logic [7:0] uaddr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mseq_top u0 (
        .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .mem_ready(mem_ready),
        .b1_sel(b1_sel), .b2_sel(b2_sel), .alu_fn(alu_fn), .dst_ld(dst_ld),
        .mem_read(mem_read), .uaddr(uaddr)
    );

    // {opcode, expected dispatch target, expected ALU code there}
    localparam logic [14:0] VEC [6] = '{
        {4'h1, 8'h80, 3'd4},
        {4'h2, 8'h88, 3'd5},
        {4'h3, 8'h90, 3'd3},
        {4'h0, 8'h30, 3'd0},
        {4'h7, 8'h30, 3'd0},
        {4'hF, 8'h30, 3'd0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    // Run one instruction starting with 0x20 current at a negedge.
    task automatic run_instr(logic [3:0] op, logic [7:0] disp, logic [2:0] fn);
        check("R2 uaddr", uaddr, 8'h20);
        check("R2 ctl", {b1_sel, alu_fn, dst_ld, mem_read}, {2'd1, 3'd1, 3'd1, 1'b1});
        tick;
        check("R4 uaddr", uaddr, 8'h21);
        check("R4 ctl", {b1_sel, b2_sel, alu_fn, dst_ld, mem_read},
              {2'd1, 2'd1, 3'd3, 3'd2, 1'b0});
        tick;
        check("R5 uaddr", uaddr, 8'h22);
        check("R5 ctl", {b1_sel, b2_sel, alu_fn, dst_ld}, {2'd0, 2'd2, 3'd2, 3'd3});
        tick;
        check("R6 uaddr", uaddr, 8'h23);
        check("R6 idle", {b1_sel, b2_sel, alu_fn, dst_ld, mem_read}, 11'd0);
        ir_opcode = op;
        tick;
        ir_opcode = ~op;
        check("R6/R8 dispatch", uaddr, disp);
        check("R7/R10 alu", alu_fn, fn);
        if (disp != 8'h30) begin
            check("R7 srcs", {b1_sel, b2_sel, dst_ld}, {2'd2, 2'd3, 3'd4});
            tick;
            check("R7 second word", uaddr, disp + 8'd1);
            check("R11 idle", {b1_sel, b2_sel, alu_fn, dst_ld, mem_read}, 11'd0);
        end else begin
            check("R8 idle", {b1_sel, b2_sel, alu_fn, dst_ld, mem_read}, 11'd0);
        end
        tick;
        check("R7/R8 back to fetch", uaddr, 8'h20);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=5000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        check("R1 reset", uaddr, 8'h20);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 6; i++) begin
            run_instr(VEC[i][14:11], VEC[i][10:3], VEC[i][2:0]);
        end

        // R3: read stall holds at 0x20
        mem_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick;
            check("R3 hold", uaddr, 8'h20);
        end
        mem_ready = 1'b1;
        tick;
        check("R3 release", uaddr, 8'h21);

        // R9: ready low on a non-read word is ignored
        mem_ready = 1'b0;
        tick;
        check("R9 advance", uaddr, 8'h22);
        tick;
        check("R9 advance", uaddr, 8'h23);
        mem_ready = 1'b1;
        ir_opcode = 4'h1;
        tick;
        check("R7 enter AND", uaddr, 8'h80);

        // R1: reset in the middle of a routine
        rst_n = 1'b0;
        tick;
        check("R1 mid-routine reset", uaddr, 8'h20);
        rst_n = 1'b1;

        // R7: full AND sequence once more after reset
        run_instr(4'h1, 8'h80, 3'd4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule